// File: doc/BRIEF.md
# Prioritized interrupt claim arbiter

This block arbitrates a small set of level-sensitive interrupt sources among a few target contexts. It keeps, per source, a pending bit, an in-service bit and a 3-bit priority. Per context, it keeps an enable mask and a threshold. Each context has one registered request line. That line is raised whenever a source the context may take has a priority strictly above the context's threshold.

A context takes work by pulsing a claim request. In the same cycle the block returns the ID of the best eligible source. At the next clock edge that source leaves the pending set and enters the in-service set. The source then stays hidden from every context until a completion naming it arrives. Configuration (priorities, enable masks, thresholds) comes in as plain write strobes. Address decoding and routing of the request lines to processors belong to the surrounding logic.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source is eligible for a context only when its pending bit is 1, its in-service bit is 0 and its bit in that context's enable mask is 1.
- R2: `ctxIrq[c]` is a registered output. It is 1 exactly when some source eligible for context c has a priority strictly greater than that context's threshold. It reflects the state one clock edge after that state changes.
- R3: With `claimReq` high, `claimId` gives the eligible source with the highest priority above the context's threshold, in the same cycle. When priorities are equal, the lowest source ID wins.
- R4: A claim that finds no qualifying source returns ID 0 and leaves the in-service set unchanged. Source 0 is reserved: its pending bit is always 0, and it is never returned.
- R5: A successful claim clears the winner's pending bit and sets its in-service bit at the same clock edge. The source stays masked until it is completed, even while its input level stays high.
- R6: A completion (`compReq`, with an 8-bit `compId`) clears that source's in-service bit when `compId` < NUM_SRC. Otherwise it is ignored.
- R7: A priority write stores only bits [2:0] of `prioWrData`.
- R8: A threshold write is taken only if `thrWrData` <= MAX_PRIO. Otherwise the old threshold is kept.
- R9: Each pending bit follows its `srcLevel` input at every clock edge. The one exception: when a claim wins that source in the same cycle, the pending bit goes to 0 for that edge.
- R10: After reset, every pending bit, in-service bit, enable mask, priority and threshold is 0, and every `ctxIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcLevel | input | NUM_SRC | Level inputs of the sources (bit 0 unused) |
| prioWrEn | input | 1 | Priority write strobe |
| prioWrId | input | SRC_W | Source whose priority is written |
| prioWrData | input | 8 | Priority value (bits [2:0] kept) |
| enWrEn | input | 1 | Enable mask write strobe |
| enWrCtx | input | CTX_W | Context whose mask is written |
| enWrMask | input | NUM_SRC | New enable mask |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWrCtx | input | CTX_W | Context whose threshold is written |
| thrWrData | input | 8 | New threshold value |
| claimReq | input | 1 | Claim request |
| claimCtx | input | CTX_W | Claiming context |
| claimId | output | SRC_W | Winning source ID, 0 when none |
| compReq | input | 1 | Completion request |
| compId | input | 8 | Source being completed |
| ctxIrq | output | NUM_CTX | Per-context interrupt request |

## Verification
The arbiter is exercised with random mixes of levels, enable masks, priorities, thresholds, claims and completions, and each result is compared with a behavioural model of eligibility and winner selection. The random mixes show that the enable masks and the in-service masking are kept apart for each context. Directed cases cover the points random stimulus rarely reaches:
- Priorities that tie show the lowest-ID rule is used rather than a highest-ID rule.
- A priority equal to the threshold shows the comparison is strict.
- Out-of-range threshold writes and out-of-range completions show that both are rejected.
- Priority values with upper bits set show that only the low bits are stored.
- Claims against an empty eligible set show that ID 0 is returned and nothing changes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Validated strobes from control to datapath
  typedef struct packed {
    logic claimFire;
    logic compFire;
    logic thrFire;
    logic prioFire;
    logic enFire;
  } arb_strobe_t;
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int MAX_PRIO = 7,
  parameter int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic             claimReq,
  input  logic [SRC_W-1:0] winId,
  input  logic             compReq,
  input  logic [7:0]       compId,
  input  logic             thrWrEn,
  input  logic [7:0]       thrWrData,
  input  logic             prioWrEn,
  input  logic             enWrEn,
  output arb_strobe_t      strobe
);
  localparam logic [7:0] SRC_LIM  = 8'(NUM_SRC);
  localparam logic [7:0] PRIO_LIM = 8'(MAX_PRIO);

  always_comb begin
    strobe.claimFire = claimReq && (winId != '0);
    strobe.compFire  = compReq && (compId < SRC_LIM);
    strobe.thrFire   = thrWrEn && (thrWrData <= PRIO_LIM);
    strobe.prioFire  = prioWrEn;
    strobe.enFire    = enWrEn;
  end
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CTX  = 2,
  parameter int MAX_PRIO = 7,
  parameter int SRC_W    = $clog2(NUM_SRC),
  parameter int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  arb_strobe_t        strobe,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [SRC_W-1:0]   prioWrId,
  input  logic [7:0]         prioWrData,
  input  logic [CTX_W-1:0]   enWrCtx,
  input  logic [NUM_SRC-1:0] enWrMask,
  input  logic               thrWrEn,
  input  logic [CTX_W-1:0]   thrWrCtx,
  input  logic [7:0]         thrWrData,
  input  logic               claimReq,
  input  logic [CTX_W-1:0]   claimCtx,
  input  logic               compReq,
  input  logic [7:0]         compId,
  output logic [SRC_W-1:0]   winId,
  output logic [NUM_CTX-1:0] ctxIrq
);
  localparam logic [2:0] TOP_PRIO = 3'(MAX_PRIO);

  logic [NUM_SRC-1:0]              pendQ, busyQ;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0][2:0]         prioQ;
  logic [NUM_CTX-1:0][2:0]         thrQ;
  logic [NUM_CTX-1:0]              irqQ;
  logic [NUM_CTX-1:0]              irqNext;
  logic [NUM_SRC-1:0]              liveSet;

  assign liveSet = pendQ & ~busyQ;

  // Per-context request: any eligible source strictly above threshold
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    always_comb begin
      irqNext[c] = 1'b0;
      for (int i = 1; i < NUM_SRC; i++)
        if (liveSet[i] && enQ[c][i] && (prioQ[i] > thrQ[c])) irqNext[c] = 1'b1;
    end
    // R2: a threshold at the top priority can never be beaten
    p_top_thr_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
      (thrQ[c] == TOP_PRIO) |=> !ctxIrq[c]);
  end

  // Claim winner for the requesting context; strict '>' keeps the lowest ID on ties
  always_comb begin
    logic [2:0] bestPrio;
    bestPrio = thrQ[claimCtx];
    winId    = '0;
    for (int i = 1; i < NUM_SRC; i++)
      if (liveSet[i] && enQ[claimCtx][i] && (prioQ[i] > bestPrio)) begin
        bestPrio = prioQ[i];
        winId    = SRC_W'(i);
      end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      busyQ <= '0;
      enQ   <= '0;
      prioQ <= '0;
      thrQ  <= '0;
      irqQ  <= '0;
    end else begin
      pendQ    <= srcLevel;
      pendQ[0] <= 1'b0;
      if (strobe.claimFire) pendQ[winId] <= 1'b0;
      if (strobe.compFire)  busyQ[compId[SRC_W-1:0]] <= 1'b0;
      if (strobe.claimFire) busyQ[winId] <= 1'b1;
      if (strobe.enFire)    enQ[enWrCtx] <= enWrMask;
      if (strobe.prioFire)  prioQ[prioWrId] <= prioWrData[2:0];
      if (strobe.thrFire)   thrQ[thrWrCtx] <= thrWrData[2:0];
      irqQ <= irqNext;
    end
  end

  assign ctxIrq = irqQ;

  // R5: claim moves the winner from pending to in-service in one edge
  p_claim_moves_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.claimFire |=> (busyQ[$past(winId)] && !pendQ[$past(winId)]));
  // R4: an empty claim changes no in-service bit
  p_empty_claim_r4: assert property (@(posedge clk) disable iff (!rstN)
    (claimReq && winId == '0 && !compReq) |=> $stable(busyQ));
  // R6: an out-of-range completion is ignored
  p_comp_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (compReq && compId >= 8'(NUM_SRC) && !claimReq) |=> $stable(busyQ));
  // R8: an over-range threshold write keeps the old thresholds
  p_thr_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrEn && thrWrData > 8'(MAX_PRIO)) |=> $stable(thrQ));
  // R1: a returned winner is eligible for the claiming context
  p_win_eligible_r1: assert property (@(posedge clk) disable iff (!rstN)
    (winId != '0) |-> (pendQ[winId] && !busyQ[winId] && enQ[claimCtx][winId]));
  // R4: reserved source 0 is never pending
  p_src0_idle_r4: assert property (@(posedge clk) disable iff (!rstN) !pendQ[0]);
endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CTX  = 2,
  parameter int MAX_PRIO = 7,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               prioWrEn,
  input  logic [SRC_W-1:0]   prioWrId,
  input  logic [7:0]         prioWrData,
  input  logic               enWrEn,
  input  logic [CTX_W-1:0]   enWrCtx,
  input  logic [NUM_SRC-1:0] enWrMask,
  input  logic               thrWrEn,
  input  logic [CTX_W-1:0]   thrWrCtx,
  input  logic [7:0]         thrWrData,
  input  logic               claimReq,
  input  logic [CTX_W-1:0]   claimCtx,
  output logic [SRC_W-1:0]   claimId,
  input  logic               compReq,
  input  logic [7:0]         compId,
  output logic [NUM_CTX-1:0] ctxIrq
);
  arb_strobe_t      strobe;
  logic [SRC_W-1:0] winId;

  irq_arb_ctrl #(.NUM_SRC(NUM_SRC), .MAX_PRIO(MAX_PRIO), .SRC_W(SRC_W)) u_ctrl (
    .claimReq(claimReq), .winId(winId), .compReq(compReq), .compId(compId),
    .thrWrEn(thrWrEn), .thrWrData(thrWrData), .prioWrEn(prioWrEn),
    .enWrEn(enWrEn), .strobe(strobe)
  );

  irq_arb_datapath #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .MAX_PRIO(MAX_PRIO),
                     .SRC_W(SRC_W), .CTX_W(CTX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcLevel(srcLevel),
    .prioWrId(prioWrId), .prioWrData(prioWrData),
    .enWrCtx(enWrCtx), .enWrMask(enWrMask),
    .thrWrEn(thrWrEn), .thrWrCtx(thrWrCtx), .thrWrData(thrWrData),
    .claimReq(claimReq), .claimCtx(claimCtx),
    .compReq(compReq), .compId(compId),
    .winId(winId), .ctxIrq(ctxIrq)
  );

  assign claimId = claimReq ? winId : '0;
endmodule

// File: tb/sim_irq_claim_arbiter.sv
`timescale 1ns/1ps
module sim_irq_claim_arbiter;
  localparam int NS = 16;
  localparam int NC = 2;
  localparam int MP = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] srcLevel = '0;
  logic prioWrEn = 0; logic [3:0] prioWrId = '0; logic [7:0] prioWrData = '0;
  logic enWrEn = 0;   logic [0:0] enWrCtx = '0;  logic [NS-1:0] enWrMask = '0;
  logic thrWrEn = 0;  logic [0:0] thrWrCtx = '0; logic [7:0] thrWrData = '0;
  logic claimReq = 0; logic [0:0] claimCtx = '0; logic [3:0] claimId;
  logic compReq = 0;  logic [7:0] compId = '0;
  logic [NC-1:0] ctxIrq;

  int checks = 0, errors = 0;
  bit done = 0;

  // Model state
  logic [NS-1:0] mLvl = '0, mBusy = '0;
  logic [NS-1:0] mEn [NC];
  int mPrio [NS];
  int mThr [NC];

  always #10 clk = ~clk;

  irq_claim_arbiter #(.NUM_SRC(NS), .NUM_CTX(NC), .MAX_PRIO(MP)) u0 (.*);

  function automatic int expWin(int c);
    int best = mThr[c], w = 0;
    for (int i = 1; i < NS; i++)
      if (mLvl[i] && !mBusy[i] && mEn[c][i] && mPrio[i] > best) begin best = mPrio[i]; w = i; end
    return w;
  endfunction

  function automatic bit expIrq(int c);
    for (int i = 1; i < NS; i++)
      if (mLvl[i] && !mBusy[i] && mEn[c][i] && mPrio[i] > mThr[c]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wrPrio(int id, int v);
    prioWrEn = 1; prioWrId = 4'(id); prioWrData = 8'(v); tick(); prioWrEn = 0;
    mPrio[id] = v & 7;
  endtask
  task automatic wrEn(int c, logic [NS-1:0] m);
    enWrEn = 1; enWrCtx = 1'(c); enWrMask = m; tick(); enWrEn = 0;
    mEn[c] = m;
  endtask
  task automatic wrThr(int c, int v);
    thrWrEn = 1; thrWrCtx = 1'(c); thrWrData = 8'(v); tick(); thrWrEn = 0;
    if (v <= MP) mThr[c] = v;
  endtask
  task automatic setLvl(logic [NS-1:0] l);
    srcLevel = l; mLvl = l; mLvl[0] = 1'b0;
  endtask
  task automatic chkIrq(string tag);
    tick(); tick();
    for (int c = 0; c < NC; c++) check(tag, int'(ctxIrq[c]), int'(expIrq(c)));
  endtask
  task automatic doClaim(int c, string tag, output int got);
    int w = expWin(c);
    claimReq = 1; claimCtx = 1'(c); #1;
    got = int'(claimId);
    check(tag, got, w);
    tick(); claimReq = 0;
    if (w != 0) mBusy[w] = 1'b1;
  endtask
  task automatic doComp(int id);
    compReq = 1; compId = 8'(id); tick(); compReq = 0;
    if (id < NS) mBusy[id] = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int got;
    void'($urandom(32'h5eed));
    for (int i = 0; i < NS; i++) mPrio[i] = 0;
    for (int c = 0; c < NC; c++) begin mEn[c] = '0; mThr[c] = 0; end
    tick(); tick(); rstN = 1; tick();

    // R10: reset state
    check("R10 irq after reset", int'(ctxIrq), 0);
    setLvl('1);
    wrEn(0, '1);
    doClaim(0, "R10 zero priorities give no winner", got);
    setLvl('0); wrEn(0, '0); tick(); tick();

    // R7: only low 3 bits of priority stored (0x0D -> 5)
    wrPrio(3, 8'h0D);
    wrEn(0, 16'h0008);
    setLvl(16'h0008);
    wrThr(0, 4);
    chkIrq("R7 prio 5 above thr 4");
    check("R7 irq0 high", int'(ctxIrq[0]), 1);
    // R2: equal priority and threshold does not raise the line
    wrThr(0, 5);
    chkIrq("R2 strict compare");
    check("R2 irq0 low at equal", int'(ctxIrq[0]), 0);
    // R8: over-range threshold is rejected (low bits would be 1)
    wrThr(0, 9);
    chkIrq("R8 thr 9 rejected");
    check("R8 irq0 still low", int'(ctxIrq[0]), 0);
    wrThr(0, 3);
    chkIrq("R8 thr 3 accepted");

    // R3: tie on priority 5 among 2,3,5 -> lowest id 2
    wrPrio(2, 5); wrPrio(5, 5);
    wrEn(0, 16'h002C);
    setLvl(16'h002C); tick(); tick();
    doClaim(0, "R3 tie lowest id", got);
    check("R3 winner is 2", got, 2);
    // R5: claimed source stays masked with its level still high
    tick();
    doClaim(0, "R5 masked after claim", got);
    check("R5 next is 3", got, 3);
    // R6: out-of-range completion ignored
    doComp(40); tick();
    doClaim(0, "R6 ignored completion", got);
    check("R6 next is 5", got, 5);
    // R4: nothing left -> 0, state unchanged
    tick();
    doClaim(0, "R4 empty claim", got);
    check("R4 id zero", got, 0);
    chkIrq("R4 irq after empty claim");
    // R6: valid completion frees source 2
    doComp(2); tick();
    chkIrq("R6 completion re-raises");
    doClaim(0, "R6 source 2 again", got);
    check("R6 winner 2", got, 2);
    // R1: context 1 has nothing enabled
    doClaim(1, "R1 disabled context", got);
    // R9: level drop clears pending
    doComp(2); doComp(3); doComp(5);
    setLvl('0);
    chkIrq("R9 level low");
    check("R9 irq0 low", int'(ctxIrq[0]), 0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 6));
      case (op)
        0: wrPrio(int'($urandom_range(1, NS-1)), int'($urandom_range(0, 255)));
        1: wrEn(int'($urandom_range(0, NC-1)), NS'($urandom));
        2: wrThr(int'($urandom_range(0, NC-1)), int'($urandom_range(0, 9)));
        3: setLvl(NS'($urandom));
        4: begin tick(); doClaim(int'($urandom_range(0, NC-1)), "R3 random claim", got); end
        5: doComp(int'($urandom_range(0, 20)));
        default: tick();
      endcase
      chkIrq("R2 random irq");
    end
    finishRun();
  end
endmodule